// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Edge Capture

This block is a general-purpose I/O port of up to 32 pins, controlled through a small word-addressed register bus. Software sets which pins are outputs and what level they drive. It reads back the synchronised pin levels and decides which pins may raise the single interrupt request line.

Each pin input first passes through a two-flop synchroniser. In the three edge modes, a change on the synchronised level that matches the build-time trigger type sets a sticky capture bit. Software clears that bit by writing a one to it. In the level mode no capture state exists, and the request line follows the live synchronised pins gated by the mask.

The trigger type is a build parameter and cannot change at run time. It is one of: rising edge, falling edge, either edge, or level-high. The asynchronous active-low reset is released synchronously inside the block.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the output latch, direction, mask and capture registers are all zero. `pin_oe` and `irq` are low, and `bus_rdata` is zero.
- R2: Direction bit 1 makes a pin an output and bit 0 makes it an input. `pin_oe` equals the direction register. `pin_out` carries the output latch only on pins whose direction bit is 1, and 0 on the other pins.
- R3: Reads complete one cycle after the request, and `bus_rdata` holds its value until the next read. Reading byte offset 0x0 returns the pin levels after the two-flop synchroniser. Reading 0x4, 0x8 or 0xC returns the direction, mask or capture register respectively. Writing 0x0 loads the output latch.
- R4: In rising mode (TRIGGER=0), a 0-to-1 change of a synchronised pin sets its capture bit.
- R5: In falling mode (TRIGGER=1), a 1-to-0 change of a synchronised pin sets its capture bit.
- R6: In both-edges mode (TRIGGER=2), any change of a synchronised pin sets its capture bit.
- R7: Writing a 1 to a capture bit at offset 0xC clears that bit. Writing a 0 leaves it unchanged, and capture bits stay set until they are cleared.
- R8: An edge that arrives in the same cycle as a clear of the same bit leaves the bit set.
- R9: In the edge modes, `irq` is high exactly when the AND of the capture and mask registers is nonzero. Mask bit 1 enables a pin.
- R10: In level mode (TRIGGER=3), `irq` is high exactly when the AND of the synchronised pins and the mask is nonzero. The capture register always reads zero.
- R11: Register bits at and above NUM_PINS read as zero, and writes to them have no effect.
- R12: Any byte offset other than 0x0, 0x4, 0x8 and 0xC on the 5-bit address reads as zero. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output level, qualified by direction |
| pin_oe | output | NUM_PINS | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The timing of each result is fixed relative to its stimulus:

| Result | Due after |
|---|---|
| Register writes and read data | the next clock edge |
| Level-mode request after a pin change | two edges (the synchroniser) |
| Capture bit and edge-mode request after a pin change | three edges |

The reference model in the bench applies every bus access and pin sample at the clock edge where the design samples it. It keeps a three-deep queue of sampled pin words, so each of these delays falls out of the model rather than from hand-tuned waits. All four trigger variants are built side by side on the same stimulus. Every output of every variant is compared shortly after each rising edge, including the cycle in which a clear write and an edge meet.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'd0,
    TRIG_FALL  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } trig_e;

  localparam int unsigned BUS_AW = 5;
  localparam int unsigned BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_DATA = 5'h00;
  localparam logic [BUS_AW-1:0] OFS_DIR  = 5'h04;
  localparam logic [BUS_AW-1:0] OFS_MASK = 5'h08;
  localparam logic [BUS_AW-1:0] OFS_CAP  = 5'h0C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_MASK,
    SEL_CAP
  } regsel_e;

  function automatic regsel_e decode_ofs(input logic [BUS_AW-1:0] a);
    regsel_e s;
    case (a)
      OFS_DATA: s = SEL_DATA;
      OFS_DIR:  s = SEL_DIR;
      OFS_MASK: s = SEL_MASK;
      OFS_CAP:  s = SEL_CAP;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_out = out_q;
endmodule

// File: rtl/gpio_in_stage.sv
module gpio_in_stage
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter trig_e       TRIGGER  = TRIG_RISE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] sync_o,
  output logic [NUM_PINS-1:0] edge_o
);
  logic [NUM_PINS-1:0] meta_q;
  logic [NUM_PINS-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

  if (TRIGGER == TRIG_LEVEL) begin : g_level
    assign edge_o = '0;
  end else begin : g_edge
    logic [NUM_PINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_q;
    end

    if (TRIGGER == TRIG_RISE) begin : g_rise
      assign edge_o = sync_q & ~prev_q;
    end else if (TRIGGER == TRIG_FALL) begin : g_fall
      assign edge_o = ~sync_q & prev_q;
    end else begin : g_both
      assign edge_o = sync_q ^ prev_q;
    end
  end
endmodule

// File: rtl/gpio_capture.sv
module gpio_capture
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter trig_e       TRIGGER  = TRIG_RISE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] edge_i,
  input  logic                clr_we_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] cap_o
);
  if (TRIGGER == TRIG_LEVEL) begin : g_none
    logic unused_cap;
    assign unused_cap = ^{edge_i, clr_i, clr_we_i};
    assign cap_o = '0;
  end else begin : g_sticky
    logic [NUM_PINS-1:0] cap_q;
    logic [NUM_PINS-1:0] cap_d;
    logic [NUM_PINS-1:0] clr_eff;

    always_comb begin
      clr_eff = clr_we_i ? clr_i : '0;
      cap_d   = (cap_q & ~clr_eff) | edge_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_q <= '0;
      else        cap_q <= cap_d;
    end

    assign cap_o = cap_q;

    // R8: an edge is never lost, even when a clear hits the same bit
    a_r8_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i != '0) |=> ((cap_q & $past(edge_i)) == $past(edge_i)));

    // R7: a one written to a bit without a coincident edge clears it
    a_r7_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we_i |=> ((cap_q & $past(clr_i & ~edge_i)) == '0));

    // R7: with no clear, set bits stay set
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we_i |=> ((cap_q & $past(cap_q)) == $past(cap_q)));
  end
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [BUS_AW-1:0]   addr_i,
  input  logic [BUS_DW-1:0]   wdata_i,
  input  logic [NUM_PINS-1:0] sync_i,
  input  logic [NUM_PINS-1:0] cap_i,
  output logic [NUM_PINS-1:0] out_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic                clr_we_o,
  output logic [NUM_PINS-1:0] clr_o,
  output logic [BUS_DW-1:0]   rdata_o
);
  regsel_e             sel;
  logic                wr, rd;
  logic [NUM_PINS-1:0] wlow;
  logic [NUM_PINS-1:0] out_q, dir_q, mask_q;
  logic [NUM_PINS-1:0] out_d, dir_d, mask_d;
  logic                out_en, dir_en, mask_en;
  logic [BUS_DW-1:0]   rdata_q, rdata_d;
  logic                rdata_en;

  if (NUM_PINS < BUS_DW) begin : g_pad
    logic unused_hi;
    assign unused_hi = ^wdata_i[BUS_DW-1:NUM_PINS];
  end

  function automatic logic [BUS_DW-1:0] widen(input logic [NUM_PINS-1:0] v);
    logic [BUS_DW-1:0] r;
    r = '0;
    r[NUM_PINS-1:0] = v;
    return r;
  endfunction

  always_comb begin
    sel      = decode_ofs(addr_i);
    wr       = req_i && we_i;
    rd       = req_i && !we_i;
    wlow     = wdata_i[NUM_PINS-1:0];
    out_en   = wr && (sel == SEL_DATA);
    dir_en   = wr && (sel == SEL_DIR);
    mask_en  = wr && (sel == SEL_MASK);
    out_d    = wlow;
    dir_d    = wlow;
    mask_d   = wlow;
    clr_we_o = wr && (sel == SEL_CAP);
    clr_o    = wlow;
    rdata_en = rd;
    case (sel)
      SEL_DATA: rdata_d = widen(sync_i);
      SEL_DIR:  rdata_d = widen(dir_q);
      SEL_MASK: rdata_d = widen(mask_q);
      SEL_CAP:  rdata_d = widen(cap_i);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (out_en)   out_q   <= out_d;
      if (dir_en)   dir_q   <= dir_d;
      if (mask_en)  mask_q  <= mask_d;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

  assign out_o   = out_q;
  assign dir_o   = dir_q;
  assign mask_o  = mask_q;
  assign rdata_o = rdata_q;

  // R12: a write to an unmapped offset changes no register
  a_r12_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_NONE) |=> ($stable(out_q) && $stable(dir_q) && $stable(mask_q)));

  // R3: the read data returns the synchronised pins one cycle after the request
  a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_DATA) |=> (rdata_o == widen($past(sync_i))));

  // R3: read data holds between reads
  a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(rdata_o));
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter trig_e       TRIGGER  = TRIG_RISE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [4:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  logic                rst_n_int;
  logic [NUM_PINS-1:0] sync_w, edge_w, cap_w;
  logic [NUM_PINS-1:0] out_w, dir_w, mask_w, clr_w;
  logic                clr_we_w;

  gpio_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  gpio_in_stage #(.NUM_PINS(NUM_PINS), .TRIGGER(TRIGGER)) u_in_stage (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .pin_i  (pin_in),
    .sync_o (sync_w),
    .edge_o (edge_w)
  );

  gpio_capture #(.NUM_PINS(NUM_PINS), .TRIGGER(TRIGGER)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .edge_i   (edge_w),
    .clr_we_i (clr_we_w),
    .clr_i    (clr_w),
    .cap_o    (cap_w)
  );

  gpio_reg_file #(.NUM_PINS(NUM_PINS)) u_reg_file (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .req_i    (bus_req),
    .we_i     (bus_we),
    .addr_i   (bus_addr),
    .wdata_i  (bus_wdata),
    .sync_i   (sync_w),
    .cap_i    (cap_w),
    .out_o    (out_w),
    .dir_o    (dir_w),
    .mask_o   (mask_w),
    .clr_we_o (clr_we_w),
    .clr_o    (clr_w),
    .rdata_o  (bus_rdata)
  );

  if (TRIGGER == TRIG_LEVEL) begin : g_irq_level
    logic unused_cap;
    assign unused_cap = ^cap_w;
    assign irq = |(sync_w & mask_w);
  end else begin : g_irq_edge
    assign irq = |(cap_w & mask_w);
  end

  assign pin_oe  = dir_w;
  assign pin_out = out_w & dir_w;

  // R9: with every pin masked the request line stays low
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mask_w == '0) |-> !irq);

  // R2: no pin is driven high unless it is enabled as an output
  a_r2_drive_gated: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((pin_out & ~pin_oe) == '0));
endmodule

// File: tb/gpio_edge_port_bench.sv
`timescale 1ns/1ps
module gpio_edge_port_bench;
  import gpio_edge_pkg::*;

  localparam int N = 16;
  localparam int MAX_CYC = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [N-1:0] pins = '0;

  logic [31:0]  rdata [4];
  logic [N-1:0] pout  [4];
  logic [N-1:0] poe   [4];
  logic         irqv  [4];

  int    vectors = 0;
  int    errors  = 0;
  bit    active  = 1'b0;
  bit    done    = 1'b0;
  string phase   = "R1";

  always #4 clk = ~clk;

  gpio_edge_port #(.NUM_PINS(N), .TRIGGER(TRIG_RISE)) u_gpio_edge_port (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata[0]), .pin_in(pins),
    .pin_out(pout[0]), .pin_oe(poe[0]), .irq(irqv[0]));
  gpio_edge_port #(.NUM_PINS(N), .TRIGGER(TRIG_FALL)) u_gpio_edge_port_fall (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata[1]), .pin_in(pins),
    .pin_out(pout[1]), .pin_oe(poe[1]), .irq(irqv[1]));
  gpio_edge_port #(.NUM_PINS(N), .TRIGGER(TRIG_BOTH)) u_gpio_edge_port_both (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata[2]), .pin_in(pins),
    .pin_out(pout[2]), .pin_oe(poe[2]), .irq(irqv[2]));
  gpio_edge_port #(.NUM_PINS(N), .TRIGGER(TRIG_LEVEL)) u_gpio_edge_port_level (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata[3]), .pin_in(pins),
    .pin_out(pout[3]), .pin_oe(poe[3]), .irq(irqv[3]));

  // ---------------- reference model ----------------
  logic [N-1:0]  hist [$];
  logic [N-1:0]  m_out, m_dir, m_mask;
  logic [N-1:0]  m_cap   [4];
  logic [31:0]   m_rdata [4];

  function automatic logic [31:0] model_read(int m, logic [4:0] a, logic [N-1:0] s);
    logic [N-1:0] v;
    case (a)
      5'h00:   v = s;
      5'h04:   v = m_dir;
      5'h08:   v = m_mask;
      5'h0C:   v = (m == 3) ? '0 : m_cap[m];
      default: v = '0;
    endcase
    return 32'(v);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{N'(0), N'(0), N'(0)};
      m_out = '0; m_dir = '0; m_mask = '0;
      for (int m = 0; m < 4; m++) begin m_cap[m] = '0; m_rdata[m] = '0; end
    end else begin
      logic [N-1:0] s_old, p_old, clr;
      logic [N-1:0] ev [4];
      s_old = hist[1];
      p_old = hist[2];
      ev[0] = s_old & ~p_old;
      ev[1] = ~s_old & p_old;
      ev[2] = s_old ^ p_old;
      ev[3] = '0;
      if (req && !we)
        for (int m = 0; m < 4; m++) m_rdata[m] = model_read(m, addr, s_old);
      clr = (req && we && addr == 5'h0C) ? wdata[N-1:0] : '0;
      if (req && we) begin
        case (addr)
          5'h00: m_out  = wdata[N-1:0];
          5'h04: m_dir  = wdata[N-1:0];
          5'h08: m_mask = wdata[N-1:0];
          default: ;
        endcase
      end
      for (int m = 0; m < 3; m++) m_cap[m] = (m_cap[m] & ~clr) | ev[m];
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  task automatic check1(string req_tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req_tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (active) begin
      string mt [4];
      mt[0] = "R4 R9"; mt[1] = "R5 R9"; mt[2] = "R6 R9"; mt[3] = "R10";
      for (int m = 0; m < 4; m++) begin
        logic e_irq;
        e_irq = (m == 3) ? |(hist[1] & m_mask) : |(m_cap[m] & m_mask);
        check1(mt[m], "irq", 32'(irqv[m]), 32'(e_irq));
        check1("R2", "pin_oe", 32'(poe[m]), 32'(m_dir));
        check1("R2", "pin_out", 32'(pout[m]), 32'(m_out & m_dir));
        check1(phase, "rdata", rdata[m], m_rdata[m]);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(logic [N-1:0] p);
    @(negedge clk); pins = p;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    active = 1'b1;

    phase = "R1";
    rd(5'h00); rd(5'h04); rd(5'h08); rd(5'h0C);

    phase = "R2";
    wr(5'h04, 32'h0000_00FF);
    wr(5'h00, 32'h0000_0F0F);
    rd(5'h04); idle(2);
    wr(5'h04, 32'h0000_F0F0); idle(2);

    phase = "R11";
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08);
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04);
    wr(5'h08, 32'h0000_0000); wr(5'h04, 32'h0000_0000);

    phase = "R12";
    wr(5'h04, 32'h0000_1234);
    wr(5'h10, 32'hFFFF_FFFF); wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h02, 32'hFFFF_FFFF); wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h10); rd(5'h02); rd(5'h1F); rd(5'h04); rd(5'h08);

    phase = "R3";
    set_pins(16'hA5C3); idle(1); rd(5'h00); idle(3); rd(5'h00);
    set_pins(16'h5A3C); rd(5'h00); rd(5'h00); rd(5'h00);

    phase = "R9";
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h08, 32'h0000_00FF);
    set_pins(16'h0000); idle(4);
    set_pins(16'h0001); idle(4); rd(5'h0C);
    set_pins(16'h0000); idle(4); rd(5'h0C);
    set_pins(16'h0100); idle(4); rd(5'h0C);

    phase = "R7";
    wr(5'h0C, 32'h0000_0000); rd(5'h0C);
    wr(5'h0C, 32'h0000_0001); rd(5'h0C);
    wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C);

    phase = "R8";
    for (int off = 0; off < 6; off++) begin
      set_pins(16'h0000); idle(5);
      wr(5'h0C, 32'hFFFF_FFFF);
      set_pins(16'h0003);
      idle(off);
      wr(5'h0C, 32'h0000_0003);
      rd(5'h0C); idle(4); rd(5'h0C);
    end

    phase = "R10";
    wr(5'h08, 32'h0000_0010);
    set_pins(16'h0010); idle(4); rd(5'h0C);
    set_pins(16'h0020); idle(4);
    wr(5'h08, 32'h0000_0000); set_pins(16'hFFFF); idle(4);

    phase = "R9";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      pins  = ($urandom_range(0, 3) == 0) ? N'($urandom) : pins;
      req   = ($urandom_range(0, 2) == 0);
      we    = $urandom_range(0, 1) == 1;
      addr  = ($urandom_range(0, 7) == 0) ? 5'($urandom) : {1'b0, 2'($urandom), 2'b00};
      wdata = $urandom;
    end
    @(negedge clk); req = 1'b0;
    idle(6);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule